// File: doc/BRIEF.md
# Collating Field Compare Unit

This unit compares two character fields held in a shared character memory and reports how the B field ranks against the A field. A command gives the units (lowest-order) addresses of both fields. The unit then steps toward lower addresses, one position at a time. At each position it fetches the A character and then the B character through a single read port. Each memory word is a 6-bit character code plus a word-mark bit. The read port has one cycle of latency. A word mark flags the high-order end of a field.

Characters are ranked by a fixed collating sequence, not by their binary value. Four sticky indicators hold the outcome: equal, unequal, low (B below A) and high (B above A). A later command can be chained to an earlier one so that an unequal outcome already recorded is kept. A separate clear input lets an unrelated operation reset the indicators.

The control is a five-state machine:
- IDLE waits for `start`. IDLE to FETCH_A happens when a command is accepted.
- FETCH_A reads the A character. FETCH_A to FETCH_B is unconditional.
- FETCH_B reads the B character and captures the returning A character. FETCH_B to EVAL is unconditional.
- EVAL judges the position. EVAL goes back to FETCH_A when neither word mark was seen, with both addresses decremented. EVAL goes to FINISH when a word mark ends the scan.
- FINISH raises `done`. FINISH to IDLE is unconditional.

Top module: `coll_field_cmp`

## Requirements
- R1: After reset all four indicators, `done`, `busy` and `rd_en` are 0.
- R2: Character code = {zone[1:0], num[3:0]}. Blank is 6'h00. Digits 1..9 are zone 00 with num 1..9, and digit 0 is 6'h0A. Letters A..I are zone 11 with num 1..9. Letters J..R are zone 10 with num 1..9. Letters S..Z are zone 01 with num 2..9. Every other code is a special character. The collating order from low to high is: blank, specials (ordered by raw code), A..I, J..R, S..Z, then digits 0..9.
- R3: Two characters are equal only when all 6 code bits match. For example, 6'h3A (a signed zero) is a special character and does not equal 6'h0A.
- R4: When the fields differ, the highest-order differing position that is scanned sets low or high.
- R5: Positions are scanned from the units addresses downward. Each position issues a read of the A address and then a read of the B address, in consecutive cycles.
- R6: A word mark on the B character ends the compare after that position. A-field positions beyond it are never read or compared.
- R7: If the A word mark is reached at a position where B has no word mark, the compare ends and the result is forced to unequal with high set.
- R8: After an unchained compare, exactly one of equal or unequal is set, and unequal is set exactly when one of low or high is set. The indicators hold while the unit is idle unless `clr` or a new command arrives.
- R9: Starting a command with `chain`=0 clears all indicators on the accepting edge.
- R10: With `chain`=1, indicators from before are kept during the scan. If unequal was already set at the end, it is kept; otherwise the new result is loaded.
- R11: `clr` clears all indicators on the next edge and takes priority over a result load.
- R12: `done` is a one-cycle pulse in FINISH, after the last position. `busy` is high from the accepting edge through FINISH.
- R13: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command request, accepted in IDLE |
| chain | input | 1 | Keep earlier unequal outcome (sampled with start) |
| a_units | input | ADDR_W | Units address of the A field |
| b_units | input | ADDR_W | Units address of the B field |
| clr | input | 1 | Clear all indicators |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_char | input | 6 | Character returned one cycle after the request |
| rd_wm | input | 1 | Word mark returned with the character |
| ind_equal | output | 1 | B equals A |
| ind_unequal | output | 1 | B differs from A |
| ind_low | output | 1 | B below A |
| ind_high | output | 1 | B above A |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |

## Verification
The properties assume that `rd_char` and `rd_wm` come from a memory that answers every read exactly one cycle later. They also assume that `clr` is never asserted in the cycle before `done` when exactly one of equal or unequal is expected. The bench models the memory as a registered array. It pulses `clr` only while the unit is idle and places a word mark on the high-order character of each field it loads. Fields stay far from address zero, so the downward scan never wraps.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    localparam int CHAR_W = 6;
    localparam int RANK_W = CHAR_W + 2;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LO = 2'd1,
        REL_HI = 2'd2
    } rel_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FETCH_A = 3'd1,
        ST_FETCH_B = 3'd2,
        ST_EVAL    = 3'd3,
        ST_FINISH  = 3'd4
    } state_e;
endpackage

// File: rtl/cfc_rank.sv
module cfc_rank
    import cfc_pkg::*;
(
    input  logic [CHAR_W-1:0] code,
    output logic [RANK_W-1:0] rank
);
    logic [1:0] zone;
    logic [3:0] num;
    logic       num_1_9;

    assign zone    = code[5:4];
    assign num     = code[3:0];
    assign num_1_9 = (num >= 4'd1) && (num <= 4'd9);

    // rank = {class, sub}: class 0 blank, 1 special, 2 letter, 3 digit
    always_comb begin
        if (code == '0) begin
            rank = '0;
        end else if (zone == 2'b00 && (num_1_9 || num == 4'd10)) begin
            rank = {2'd3, 2'b00, (num == 4'd10) ? 4'd0 : num};
        end else if (zone == 2'b11 && num_1_9) begin
            rank = {2'd2, 2'd0, num};
        end else if (zone == 2'b10 && num_1_9) begin
            rank = {2'd2, 2'd1, num};
        end else if (zone == 2'b01 && num >= 4'd2 && num <= 4'd9) begin
            rank = {2'd2, 2'd2, num};
        end else begin
            rank = {2'd1, code};
        end
    end
endmodule

// File: rtl/cfc_seq.sv
module cfc_seq
    import cfc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chain,
    input  logic [ADDR_W-1:0] a_units,
    input  logic [ADDR_W-1:0] b_units,
    input  logic [CHAR_W-1:0] rd_char,
    input  logic              rd_wm,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              launch,
    output logic              launch_chain,
    output logic              eval,
    output logic              stop,
    output logic              chain_q,
    output logic [CHAR_W-1:0] a_code_q,
    output logic              a_wm_q,
    output logic              busy,
    output logic              done
);
    state_e            state, state_nx;
    logic [ADDR_W-1:0] a_ptr, b_ptr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_FETCH_A;
            ST_FETCH_A: state_nx = ST_FETCH_B;
            ST_FETCH_B: state_nx = ST_EVAL;
            ST_EVAL:    state_nx = stop ? ST_FINISH : ST_FETCH_A;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en        = 1'b0;
        rd_addr      = a_ptr;
        launch       = 1'b0;
        launch_chain = 1'b0;
        eval         = 1'b0;
        stop         = 1'b0;
        busy         = 1'b1;
        done         = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy         = 1'b0;
                launch       = start;
                launch_chain = start & chain;
            end
            ST_FETCH_A: begin
                rd_en   = 1'b1;
                rd_addr = a_ptr;
            end
            ST_FETCH_B: begin
                rd_en   = 1'b1;
                rd_addr = b_ptr;
            end
            ST_EVAL: begin
                eval = 1'b1;
                stop = rd_wm | a_wm_q;
            end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_ptr    <= '0;
            b_ptr    <= '0;
            chain_q  <= 1'b0;
            a_code_q <= '0;
            a_wm_q   <= 1'b0;
        end else begin
            if (launch) begin
                a_ptr   <= a_units;
                b_ptr   <= b_units;
                chain_q <= chain;
            end
            if (state == ST_FETCH_B) begin
                a_code_q <= rd_char;
                a_wm_q   <= rd_wm;
            end
            if (eval && !stop) begin
                a_ptr <= a_ptr - 1'b1;
                b_ptr <= b_ptr - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfc_judge.sv
module cfc_judge
    import cfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              eval,
    input  logic [CHAR_W-1:0] a_code,
    input  logic              a_wm,
    input  logic [CHAR_W-1:0] b_code,
    input  logic              b_wm,
    output rel_e              final_rel
);
    logic [RANK_W-1:0] rank_v [2];
    logic [CHAR_W-1:0] code_v [2];
    rel_e              rel_run, rel_step;

    assign code_v[0] = a_code;
    assign code_v[1] = b_code;

    for (genvar g = 0; g < 2; g++) begin : g_rank
        cfc_rank i_rank (
            .code (code_v[g]),
            .rank (rank_v[g])
        );
    end

    // every differing position overrides: the last scanned (highest order) wins
    always_comb begin
        if (a_code != b_code)
            rel_step = (rank_v[1] > rank_v[0]) ? REL_HI : REL_LO;
        else
            rel_step = rel_run;
        final_rel = (a_wm && !b_wm) ? REL_HI : rel_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rel_run <= REL_EQ;
        else if (launch) rel_run <= REL_EQ;
        else if (eval)   rel_run <= rel_step;
    end
endmodule

// File: rtl/cfc_ind.sv
module cfc_ind
    import cfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic launch,
    input  logic launch_chain,
    input  logic load,
    input  logic chain_q,
    input  rel_e final_rel,
    output logic ind_equal,
    output logic ind_unequal,
    output logic ind_low,
    output logic ind_high
);
    logic keep_old;
    assign keep_old = chain_q && ind_unequal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ind_equal   <= 1'b0;
            ind_unequal <= 1'b0;
            ind_low     <= 1'b0;
            ind_high    <= 1'b0;
        end else if (clr || (launch && !launch_chain)) begin
            ind_equal   <= 1'b0;
            ind_unequal <= 1'b0;
            ind_low     <= 1'b0;
            ind_high    <= 1'b0;
        end else if (load && !keep_old) begin
            ind_equal   <= (final_rel == REL_EQ);
            ind_unequal <= (final_rel != REL_EQ);
            ind_low     <= (final_rel == REL_LO);
            ind_high    <= (final_rel == REL_HI);
        end
    end
endmodule

// File: rtl/coll_field_cmp.sv
module coll_field_cmp
    import cfc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chain,
    input  logic [ADDR_W-1:0] a_units,
    input  logic [ADDR_W-1:0] b_units,
    input  logic              clr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [5:0]        rd_char,
    input  logic              rd_wm,
    output logic              ind_equal,
    output logic              ind_unequal,
    output logic              ind_low,
    output logic              ind_high,
    output logic              busy,
    output logic              done
);
    logic              launch, launch_chain, eval, stop, chain_q, a_wm_q;
    logic [CHAR_W-1:0] a_code_q;
    rel_e              final_rel;

    cfc_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .chain        (chain),
        .a_units      (a_units),
        .b_units      (b_units),
        .rd_char      (rd_char),
        .rd_wm        (rd_wm),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .launch       (launch),
        .launch_chain (launch_chain),
        .eval         (eval),
        .stop         (stop),
        .chain_q      (chain_q),
        .a_code_q     (a_code_q),
        .a_wm_q       (a_wm_q),
        .busy         (busy),
        .done         (done)
    );

    cfc_judge i_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .eval      (eval),
        .a_code    (a_code_q),
        .a_wm      (a_wm_q),
        .b_code    (rd_char),
        .b_wm      (rd_wm),
        .final_rel (final_rel)
    );

    cfc_ind i_ind (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .launch       (launch),
        .launch_chain (launch_chain),
        .load         (stop),
        .chain_q      (chain_q),
        .final_rel    (final_rel),
        .ind_equal    (ind_equal),
        .ind_unequal  (ind_unequal),
        .ind_low      (ind_low),
        .ind_high     (ind_high)
    );
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic chain,
    input logic clr,
    input logic rd_en,
    input logic busy,
    input logic done,
    input logic ind_equal,
    input logic ind_unequal,
    input logic ind_low,
    input logic ind_high
);
    logic any_ind;
    assign any_ind = ind_equal | ind_unequal | ind_low | ind_high;

    assert_eq_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ind_equal |-> !(ind_unequal || ind_low || ind_high));

    assert_uneq_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ind_unequal |-> $onehot({ind_low, ind_high}));

    assert_dir_uneq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_low || ind_high) |-> ind_unequal);

    assert_done_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(clr) && !$past(chain)) |-> (ind_equal ^ ind_unequal));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !clr) |=> $stable({ind_equal, ind_unequal, ind_low, ind_high}));

    assert_start_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !chain) |=> !any_ind);

    assert_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_ind);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_no_read_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_en);

    assert_busy_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind coll_field_cmp cfc_checker i_cfc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .chain       (chain),
    .clr         (clr),
    .rd_en       (rd_en),
    .busy        (busy),
    .done        (done),
    .ind_equal   (ind_equal),
    .ind_unequal (ind_unequal),
    .ind_low     (ind_low),
    .ind_high    (ind_high)
);

// File: tb/test_coll_field_cmp.sv
module test_coll_field_cmp;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int A_U        = 20;
    localparam int B_U        = 40;

    typedef struct packed {
        logic [23:0] a;
        logic [2:0]  al;
        logic [23:0] b;
        logic [2:0]  bl;
        logic [1:0]  ex;   // 0 equal, 1 low, 2 high
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{{12'h0, 6'h01, 6'h02}, 3'd2, {12'h0, 6'h01, 6'h02}, 3'd2, 2'd0},
        '{{12'h0, 6'h01, 6'h02}, 3'd2, {12'h0, 6'h01, 6'h03}, 3'd2, 2'd2},
        '{{18'h0, 6'h05}, 3'd1, {18'h0, 6'h31}, 3'd1, 2'd1},
        '{{18'h0, 6'h31}, 3'd1, {18'h0, 6'h21}, 3'd1, 2'd2},
        '{{18'h0, 6'h12}, 3'd1, {18'h0, 6'h19}, 3'd1, 2'd2},
        '{{18'h0, 6'h19}, 3'd1, {18'h0, 6'h0A}, 3'd1, 2'd2},
        '{{18'h0, 6'h00}, 3'd1, {18'h0, 6'h0B}, 3'd1, 2'd2},
        '{{18'h0, 6'h0B}, 3'd1, {18'h0, 6'h31}, 3'd1, 2'd2},
        '{{18'h0, 6'h3A}, 3'd1, {18'h0, 6'h0A}, 3'd1, 2'd2},
        '{{18'h0, 6'h09}, 3'd1, {18'h0, 6'h0A}, 3'd1, 2'd1},
        '{{12'h0, 6'h01, 6'h09}, 3'd2, {12'h0, 6'h02, 6'h08}, 3'd2, 2'd2},
        '{{12'h0, 6'h02, 6'h08}, 3'd2, {12'h0, 6'h01, 6'h09}, 3'd2, 2'd1},
        '{{6'h0, 6'h05, 6'h01, 6'h02}, 3'd3, {12'h0, 6'h01, 6'h02}, 3'd2, 2'd0},
        '{{12'h0, 6'h09, 6'h09}, 3'd2, {6'h0, 6'h01, 6'h01, 6'h01}, 3'd3, 2'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          chain = 1'b0;
    logic          clr = 1'b0;
    logic [AW-1:0] a_units = AW'(A_U);
    logic [AW-1:0] b_units = AW'(B_U);
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [5:0]    rd_char;
    logic          rd_wm;
    logic          ind_equal, ind_unequal, ind_low, ind_high, busy, done;

    logic [6:0]    mem [1 << AW];
    logic [AW-1:0] rd_log [8];
    int            rd_count = 0;
    int            checks = 0;
    int            failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    coll_field_cmp #(.ADDR_W(AW)) i_coll_field_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .chain       (chain),
        .a_units     (a_units),
        .b_units     (b_units),
        .clr         (clr),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_char     (rd_char),
        .rd_wm       (rd_wm),
        .ind_equal   (ind_equal),
        .ind_unequal (ind_unequal),
        .ind_low     (ind_low),
        .ind_high    (ind_high),
        .busy        (busy),
        .done        (done)
    );

    // memory with one cycle of read latency
    always @(posedge clk) begin
        if (rd_en) begin
            {rd_wm, rd_char} <= mem[rd_addr];
            rd_log[rd_count % 8] <= rd_addr;
            rd_count <= rd_count + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_ind(input logic [1:0] ex, input string tag);
        logic [3:0] act, want;
        act = {ind_equal, ind_unequal, ind_low, ind_high};
        want = (ex == 2'd0) ? 4'b1000 : (ex == 2'd1) ? 4'b0110 : 4'b0101;
        check(act == want, tag, act, want);
    endtask

    task automatic load_vec(input vec_t v);
        for (int i = 0; i < (1 << AW); i++) mem[i] = 7'h15;
        for (int i = 0; i < int'(v.al); i++)
            mem[A_U - i] = {(i == int'(v.al) - 1), v.a[i*6 +: 6]};
        for (int i = 0; i < int'(v.bl); i++)
            mem[B_U - i] = {(i == int'(v.bl) - 1), v.b[i*6 +: 6]};
    endtask

    // start a command, then wait for done; returns at the negedge where done is high
    task automatic run_cmp(input bit chn, input bit chk_clear, input bit restart_mid);
        int n;
        @(negedge clk);
        start = 1'b1;
        chain = chn;
        @(negedge clk);
        start = 1'b0;
        chain = 1'b0;
        if (chk_clear)
            check({ind_equal, ind_unequal, ind_low, ind_high} == 4'b0,
                  "R9 unchained start clears", {ind_equal, ind_unequal, ind_low, ind_high}, 0);
        if (restart_mid) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R12 done reached", done, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        for (int i = 0; i < (1 << AW); i++) mem[i] = 7'h15;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({ind_equal, ind_unequal, ind_low, ind_high, done, busy, rd_en} == 7'b0,
              "R1 reset outputs", {ind_equal, ind_unequal, ind_low, ind_high, done, busy, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of vectors: R2 R3 R4 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            load_vec(VECS[k]);
            run_cmp(1'b0, 1'b0, 1'b0);
            check_ind(VECS[k].ex, $sformatf("R2/R8 vector %0d", k));
            @(negedge clk);
            check(done == 1'b0 && busy == 1'b0, "R12 done one cycle", {done, busy}, 0);
        end

        // R5 scan order: A then B, units first, then downward
        load_vec(VECS[1]);
        base = rd_count;
        run_cmp(1'b0, 1'b0, 1'b0);
        check(rd_count - base == 4, "R5 read count", rd_count - base, 4);
        check(rd_log[base % 8] == AW'(A_U), "R5 first read A units", rd_log[base % 8], A_U);
        check(rd_log[(base + 1) % 8] == AW'(B_U), "R5 second read B units", rd_log[(base + 1) % 8], B_U);
        check(rd_log[(base + 2) % 8] == AW'(A_U - 1), "R5 third read A next", rd_log[(base + 2) % 8], A_U - 1);

        // R6 longer A: extra A position never read
        load_vec(VECS[12]);
        base = rd_count;
        run_cmp(1'b0, 1'b0, 1'b0);
        check(rd_count - base == 4, "R6 A beyond B mark not read", rd_count - base, 4);
        check_ind(2'd0, "R6 A beyond B mark ignored");

        // R7 shorter A stops at A mark
        load_vec(VECS[13]);
        base = rd_count;
        run_cmp(1'b0, 1'b0, 1'b0);
        check(rd_count - base == 4, "R7 stop at A mark", rd_count - base, 4);
        check_ind(2'd2, "R7 forced high");

        // R9 unchained start clears (previous result high)
        load_vec(VECS[0]);
        run_cmp(1'b0, 1'b1, 1'b0);
        check_ind(2'd0, "R9 new result after clear");

        // R10 chaining: earlier unequal kept
        load_vec(VECS[2]);
        run_cmp(1'b0, 1'b0, 1'b0);
        load_vec(VECS[0]);
        run_cmp(1'b1, 1'b0, 1'b0);
        check_ind(2'd1, "R10 chained keeps earlier low");
        // R10 chaining: earlier equal replaced
        run_cmp(1'b0, 1'b0, 1'b0);
        load_vec(VECS[1]);
        run_cmp(1'b1, 1'b0, 1'b0);
        check_ind(2'd2, "R10 chained loads new high");

        // R8 hold while idle
        repeat (5) @(negedge clk);
        check_ind(2'd2, "R8 indicators hold");

        // R11 clear
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check({ind_equal, ind_unequal, ind_low, ind_high} == 4'b0, "R11 clr clears",
              {ind_equal, ind_unequal, ind_low, ind_high}, 0);

        // R13 start while busy ignored
        load_vec(VECS[0]);
        base = rd_count;
        run_cmp(1'b0, 1'b0, 1'b1);
        check_ind(2'd0, "R13 result unaffected");
        repeat (4) @(negedge clk);
        check(rd_count - base == 4 && busy == 1'b0, "R13 no second command",
              rd_count - base, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule